// File: doc/BRIEF.md
# Aliased flag and modulus CSR bank

This block is a small register bank that sits behind a CSR access port. It holds two kinds of state. The first is an 8-bit arithmetic flag word, built from two 4-bit flag groups. The second is a 256-bit modulus register. Software sees this storage through 12-bit CSR addresses, and several of those addresses overlap on the same bits. The flag word can be reached as one combined register or as two per-group registers. The modulus is reached as eight 32-bit windows.

Each access presents an address, write data, a write enable and a set-bits select. The set-bits select turns a write into an OR with the current value of the addressed view. Read data follows the address combinationally. A write takes effect on the next rising edge. A writing access to an address outside the map changes nothing and raises a one-cycle illegal pulse. A separate side port lets the arithmetic datapath load either flag group directly. A CSR write to the same group wins over that side port.

Top module: `flagmod_csr_bank`

## Requirements
- R1: After reset the flag word, the whole modulus and the illegal pulse are all zero.
- R2: Address 0x7C8 is the combined flag view. It reads as {24'b0, group1, group0}, with group 0 in bits [3:0] and group 1 in bits [7:4]. A write loads both groups from write data bits [7:0] and ignores bits [31:8].
- R3: Address 0x7C0 reads group 0 and address 0x7C1 reads group 1. The group is returned in bits [3:0] and bits [31:4] read as zero.
- R4: A write to a group view replaces only that group, taking it from write data bits [3:0]. The other group keeps its value.
- R5: When dp_flag_we_i[g] is high, group g loads dp_flags_i[4g+3:4g]. Within a group, bit 0 is carry, bit 1 is the result MSB, bit 2 is the result LSB and bit 3 is zero. The other group is untouched.
- R6: Address 0x7D0+i (i = 0..7) reads modulus bits [32i+31:32i].
- R7: A write to modulus window i changes only those 32 bits. The other 224 bits are unchanged.
- R8: With csr_set_i high, the value written is the current read value of the addressed view ORed with the write data. The view's own placement rules then apply.
- R9: A read of an unmapped address returns zero. A write to an unmapped address changes no flag or modulus bit. In the cycle after such a write, csr_illegal_o is high for exactly one cycle, and it is low after any mapped write.
- R10: If a CSR write covers a flag group, it takes priority over a datapath update of that group in the same cycle. A group that the CSR write does not cover still takes the datapath update.
- R11: Read data reflects state combinationally. A write is not visible before the next rising edge and is visible right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Source operand for a write |
| csr_we_i | input | 1 | Write enable |
| csr_set_i | input | 1 | Write ORs into the current view value |
| csr_rdata_o | output | 32 | Combinational read data of the addressed view |
| csr_illegal_o | output | 1 | One-cycle pulse after a write to an unmapped address |
| dp_flag_we_i | input | 2 | Per-group datapath flag load enables |
| dp_flags_i | input | 8 | Datapath flag values, group g in bits [4g+3:4g] |
| flags_o | output | 8 | Current flag word |
| mod_o | output | 256 | Current modulus |

## Verification
The bench writes through one group view and reads back through the other views. A design that merges group writes badly would clobber the neighbouring group, or would leak high write bits into the word. Set-bits writes are made to both groups, the combined view and a modulus window. This catches a design that ORs with the wrong view or with the raw storage. The bench also covers three more cases:
- An unmapped write must leave every bit intact and give a single illegal pulse.
- A CSR write and a datapath update to the flags in the same cycle must resolve per group.
- A window write must not spill into its neighbours.

// File: rtl/flagmod_csr_bank.sv
module flagmod_csr_bank #(
  parameter int AW        = 12,
  parameter int DW        = 32,
  parameter int GRP_W     = 4,
  parameter int N_GRP     = 2,
  parameter int MOD_WORDS = 8,
  parameter logic [AW-1:0] GRP_BASE   = 12'h7C0,
  parameter logic [AW-1:0] FLAGS_ADDR = 12'h7C8,
  parameter logic [AW-1:0] MOD_BASE   = 12'h7D0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [AW-1:0]            csr_addr_i,
  input  logic [DW-1:0]            csr_wdata_i,
  input  logic                     csr_we_i,
  input  logic                     csr_set_i,
  output logic [DW-1:0]            csr_rdata_o,
  output logic                     csr_illegal_o,
  input  logic [N_GRP-1:0]         dp_flag_we_i,
  input  logic [GRP_W*N_GRP-1:0]   dp_flags_i,
  output logic [GRP_W*N_GRP-1:0]   flags_o,
  output logic [DW*MOD_WORDS-1:0]  mod_o
);
  localparam int FW   = GRP_W * N_GRP;
  localparam int MODW = DW * MOD_WORDS;

  logic [FW-1:0]        flags_q, flags_d;
  logic [MODW-1:0]      mod_q;
  logic [N_GRP-1:0]     hit_grp;
  logic [MOD_WORDS-1:0] hit_mod;
  logic                 hit_flags, mapped;
  logic [DW-1:0]        wval;

  assign hit_flags = (csr_addr_i == FLAGS_ADDR);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp_dec
    localparam logic [AW-1:0] GA = GRP_BASE + AW'(g);
    assign hit_grp[g] = (csr_addr_i == GA);
  end

  for (genvar w = 0; w < MOD_WORDS; w++) begin : g_mod_dec
    localparam logic [AW-1:0] MA = MOD_BASE + AW'(w);
    assign hit_mod[w] = (csr_addr_i == MA);
  end

  assign mapped = hit_flags | (|hit_grp) | (|hit_mod);

  always_comb begin
    csr_rdata_o = '0;
    if (hit_flags) csr_rdata_o[FW-1:0] = flags_q;
    for (int g = 0; g < N_GRP; g++)
      if (hit_grp[g]) csr_rdata_o[GRP_W-1:0] = flags_q[g*GRP_W +: GRP_W];
    for (int w = 0; w < MOD_WORDS; w++)
      if (hit_mod[w]) csr_rdata_o = mod_q[w*DW +: DW];
  end

  assign wval = csr_set_i ? (csr_rdata_o | csr_wdata_i) : csr_wdata_i;

  always_comb begin
    flags_d = flags_q;
    for (int g = 0; g < N_GRP; g++)
      if (dp_flag_we_i[g]) flags_d[g*GRP_W +: GRP_W] = dp_flags_i[g*GRP_W +: GRP_W];
    if (csr_we_i && hit_flags) flags_d = wval[FW-1:0];
    for (int g = 0; g < N_GRP; g++)
      if (csr_we_i && hit_grp[g]) flags_d[g*GRP_W +: GRP_W] = wval[GRP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q       <= '0;
      csr_illegal_o <= 1'b0;
    end else begin
      flags_q       <= flags_d;
      csr_illegal_o <= csr_we_i && !mapped;
    end
  end

  for (genvar w = 0; w < MOD_WORDS; w++) begin : g_mod_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     mod_q[w*DW +: DW] <= '0;
      else if (csr_we_i && hit_mod[w]) mod_q[w*DW +: DW] <= wval;
    end

    a_r7_window_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(csr_we_i && hit_mod[w]) |=> $stable(mod_o[w*DW +: DW]));
  end

  assign flags_o = flags_q;
  assign mod_o   = mod_q;

  a_r3_group_read_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_grp) |-> (csr_rdata_o[DW-1:GRP_W] == '0));

  a_r4_grp0_write_keeps_grp1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && hit_grp[0] && !dp_flag_we_i[1]) |=> $stable(flags_o[FW-1:GRP_W]));

  a_r9_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (csr_rdata_o == '0));

  a_r9_illegal_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !mapped) |=> csr_illegal_o);

  a_r9_no_spurious_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_we_i && !mapped) |=> !csr_illegal_o);

  a_r9_unmapped_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !mapped && dp_flag_we_i == '0) |=> ($stable(flags_o) && $stable(mod_o)));

  a_r10_csr_wins_combined: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && hit_flags && !csr_set_i) |=> (flags_o == $past(csr_wdata_i[FW-1:0])));

endmodule

// File: tb/flagmod_csr_bank_bench.sv
`timescale 1ns/1ps
module flagmod_csr_bank_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic         we = 1'b0, set = 1'b0;
  logic [31:0]  rdata;
  logic         illegal;
  logic [1:0]   dp_we = '0;
  logic [7:0]   dp_flags = '0;
  logic [7:0]   flags;
  logic [255:0] modv;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flagmod_csr_bank u_flagmod_csr_bank (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .csr_we_i(we), .csr_set_i(set), .csr_rdata_o(rdata), .csr_illegal_o(illegal),
    .dp_flag_we_i(dp_we), .dp_flags_i(dp_flags), .flags_o(flags), .mod_o(modv));

  typedef struct packed {
    logic        we;
    logic        set;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [11:0] raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 12'h7C8, 32'hFFFF_FFA5, 12'h7C8, 32'h0000_00A5, 4'd2},  // R2
    '{1'b0, 1'b0, 12'h000, 32'h0,         12'h7C0, 32'h0000_0005, 4'd3},  // R3
    '{1'b0, 1'b0, 12'h000, 32'h0,         12'h7C1, 32'h0000_000A, 4'd3},  // R3
    '{1'b1, 1'b0, 12'h7C0, 32'hFFFF_FFF3, 12'h7C8, 32'h0000_00A3, 4'd4},  // R4
    '{1'b1, 1'b0, 12'h7C1, 32'h0000_0006, 12'h7C8, 32'h0000_0063, 4'd4},  // R4
    '{1'b1, 1'b1, 12'h7C0, 32'h0000_0008, 12'h7C8, 32'h0000_006B, 4'd8},  // R8
    '{1'b1, 1'b1, 12'h7C1, 32'h0000_0001, 12'h7C1, 32'h0000_0007, 4'd8},  // R8
    '{1'b1, 1'b1, 12'h7C8, 32'h0000_0080, 12'h7C8, 32'h0000_00FB, 4'd8},  // R8
    '{1'b1, 1'b0, 12'h7D3, 32'hDEAD_BEEF, 12'h7D3, 32'hDEAD_BEEF, 4'd6},  // R6
    '{1'b0, 1'b0, 12'h000, 32'h0,         12'h7D2, 32'h0000_0000, 4'd7},  // R7
    '{1'b0, 1'b0, 12'h000, 32'h0,         12'h7D4, 32'h0000_0000, 4'd7},  // R7
    '{1'b1, 1'b0, 12'h7D0, 32'h1234_5678, 12'h7D3, 32'hDEAD_BEEF, 4'd7},  // R7
    '{1'b1, 1'b1, 12'h7D0, 32'h8000_0001, 12'h7D0, 32'h9234_5679, 4'd8},  // R8
    '{1'b1, 1'b0, 12'h7D7, 32'hCAFE_F00D, 12'h7D7, 32'hCAFE_F00D, 4'd6},  // R6
    '{1'b1, 1'b0, 12'h7C9, 32'hFFFF_FFFF, 12'h7C8, 32'h0000_00FB, 4'd9},  // R9
    '{1'b0, 1'b0, 12'h000, 32'h0,         12'h7CF, 32'h0000_0000, 4'd9}   // R9
  };

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d, input logic s);
    @(negedge clk);
    addr = a; wdata = d; set = s; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; set = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(tag, {224'b0, rdata}, {224'b0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 flags", {248'b0, flags}, '0);
    check("R1 mod", modv, '0);
    check("R1 illegal", {255'b0, illegal}, '0);
    read_check("R1 combined read", 12'h7C8, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) csr_write(VECS[i].addr, VECS[i].wdata, VECS[i].set);
      read_check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].raddr, VECS[i].exp);
    end

    check("R7 mod word image", modv,
          {32'hCAFE_F00D, 96'h0, 32'hDEAD_BEEF, 64'h0, 32'h9234_5679});
    check("R2 flags port", {248'b0, flags}, {248'b0, 8'hFB});

    // R9 illegal pulse lasts exactly one cycle
    @(negedge clk);
    addr = 12'h123; wdata = 32'hFFFF_FFFF; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    #1;
    check("R9 illegal high", {255'b0, illegal}, 256'd1);
    check("R9 flags kept", {248'b0, flags}, {248'b0, 8'hFB});
    @(negedge clk);
    #1;
    check("R9 illegal one cycle", {255'b0, illegal}, '0);
    csr_write(12'h7D1, 32'h1, 1'b0);
    #1;
    check("R9 no illegal on mapped write", {255'b0, illegal}, '0);

    // R11 write invisible before edge, visible after
    @(negedge clk);
    addr = 12'h7C8; wdata = 32'h0000_0011; we = 1'b1;
    #1;
    check("R11 before edge", {224'b0, rdata}, {224'b0, 32'hFB});
    @(posedge clk);
    #1;
    check("R11 after edge", {224'b0, rdata}, {224'b0, 32'h11});
    @(negedge clk);
    we = 1'b0;

    // R5 datapath load of both groups
    @(negedge clk);
    dp_we = 2'b11; dp_flags = 8'h5A;
    @(negedge clk);
    dp_we = 2'b00;
    #1;
    check("R5 datapath load", {248'b0, flags}, {248'b0, 8'h5A});
    @(negedge clk);
    dp_we = 2'b10; dp_flags = 8'hC3;
    @(negedge clk);
    dp_we = 2'b00;
    #1;
    check("R5 group1 only", {248'b0, flags}, {248'b0, 8'hCA});

    // R10 group CSR write beats datapath for its group only
    @(negedge clk);
    dp_we = 2'b11; dp_flags = 8'hFF;
    addr = 12'h7C0; wdata = 32'h0; we = 1'b1;
    @(negedge clk);
    dp_we = 2'b00; we = 1'b0;
    #1;
    check("R10 group priority", {248'b0, flags}, {248'b0, 8'hF0});
    @(negedge clk);
    dp_we = 2'b11; dp_flags = 8'hFF;
    addr = 12'h7C8; wdata = 32'h12; we = 1'b1;
    @(negedge clk);
    dp_we = 2'b00; we = 1'b0;
    #1;
    check("R10 combined priority", {248'b0, flags}, {248'b0, 8'h12});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule